// File: doc/BRIEF.md
# FIFO Level Trigger Generator

This block tracks how full a 16-entry transmit queue and a 16-entry receive queue are, using only their push and pop strobes, and raises a level trigger for each direction when the occupancy crosses a programmable point. It then steers each trigger to a shared interrupt line, to a DMA request line for that direction, or to both. The data storage itself lives elsewhere. This block sees only the strobes and keeps its own occupancy counters, so its counts follow the storage exactly.

The two thresholds are encoded differently. A transmit threshold N means "refill when only N entries remain", so the transmit trigger stays high while the occupancy is N or lower. A receive threshold N means "drain when more than N entries have arrived". The receive trigger is armed only at the moment an entry arrives and the occupancy goes above N. It drops once reads bring the occupancy back to N or lower.

Settings are loaded through a word-wide write port with a 2-bit register select. The push and pop strobes are plain single-cycle events with no back-pressure. A push to a full queue or a pop from an empty queue is dropped here, and the storage is expected to drop it the same way.

Top module: `fifo_level_trigger`

## Requirements
- R1: Each occupancy count starts at 0 and moves at the clock edge. An accepted push adds one and an accepted pop subtracts one. An accepted push and an accepted pop in the same cycle leave the count unchanged. The count never exceeds 16.
- R2: A pop while the count is 0 is ignored. A push while the count is 16 is ignored unless a pop is accepted in the same cycle.
- R3: Trigger register (select 0): bit 0 enables the transmit trigger and bits 11:8 hold its threshold N. With the enable set, tx_trig is high whenever the transmit count is N or lower, starting in the cycle after the edge that changed the count. N=15 fires as soon as the queue is no longer full.
- R4: Trigger register bit 1 enables the receive trigger and bits 19:16 hold its threshold N. An accepted receive push that leaves the count at N+1 or more raises rx_trig after that edge. N=15 fires only at 16 entries.
- R5: The receive level is evaluated only when an entry arrives. Lowering the receive threshold below the current count without a push does not raise rx_trig.
- R6: rx_trig drops as soon as the receive count is at or below the threshold. After that it stays low until a later arrival sets it again.
- R7: With a direction's enable bit clear, that direction's trigger, its DMA request and its share of irq are all low, whatever the count and threshold.
- R8: Interrupt-enable register (select 1): bit 2 passes tx_trig to irq and bit 3 passes rx_trig to irq. A write with select 3 changes no setting.
- R9: Configuration register (select 2): bit 12 passes tx_trig to tx_dma_req and bit 13 passes rx_trig to rx_dma_req. These bits are independent of the interrupt enables.
- R10: Reset clears both counts, both enables, both thresholds and all routing bits. While reset is held and after it is released, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Entry written into the transmit queue |
| tx_pop | input | 1 | Entry taken from the transmit queue |
| rx_push | input | 1 | Entry written into the receive queue |
| rx_pop | input | 1 | Entry taken from the receive queue |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 trigger, 1 interrupt enable, 2 configuration, 3 none |
| cfg_wdata | input | 32 | Register write data |
| tx_count | output | 5 | Transmit occupancy |
| rx_count | output | 5 | Receive occupancy |
| tx_trig | output | 1 | Raw transmit level trigger |
| rx_trig | output | 1 | Raw receive level trigger |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
A single stream of strobes drives both queues through three phases: a fill, then a phase with push and pop in the same cycle, then a drain. This separates the transmit threshold, which is checked whenever the count is at or below it, from the receive threshold, which is armed only on arrival and measured one entry above N. Filling to 16 with both thresholds at 15 checks the full-queue edge cases, including a push at full that is ignored and a push paired with a pop. Lowering the receive threshold with no arrival shows that the receive check waits for data, and a later single push shows it is then armed. The routing tests enable one path at a time to show that the interrupt and the DMA requests are gated independently.

// File: rtl/lvltrig_pkg.sv
package lvltrig_pkg;
  typedef enum logic [1:0] {
    SEL_TRIG = 2'd0,
    SEL_IE   = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Bit positions inside the written words
  localparam int TX_EN_BIT   = 0;
  localparam int RX_EN_BIT   = 1;
  localparam int TX_THR_LSB  = 8;
  localparam int RX_THR_LSB  = 16;
  localparam int IE_TX_BIT   = 2;
  localparam int IE_RX_BIT   = 3;
  localparam int DMA_TX_BIT  = 12;
  localparam int DMA_RX_BIT  = 13;

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int N_DIR  = 2;
endpackage

// File: rtl/lvltrig_occ.sv
module lvltrig_occ #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             push_ok
);
  localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(DEPTH);

  logic full, empty, pop_ok;

  assign full    = (count == FULL_VAL);
  assign empty   = (count == '0);
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);

  always_comb begin
    unique case ({push_ok, pop_ok})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_VAL); // R1
  AST_OCC_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(count)); // R1
  AST_OCC_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(count)); // R2
  AST_OCC_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (count == '0)); // R2
endmodule

// File: rtl/lvltrig_regs.sv
module lvltrig_regs
  import lvltrig_pkg::*;
#(
  parameter int THR_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              tx_en,
  output logic              rx_en,
  output logic [THR_W-1:0]  tx_thr,
  output logic [THR_W-1:0]  rx_thr,
  output logic              ie_tx,
  output logic              ie_rx,
  output logic              dma_tx,
  output logic              dma_rx
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      tx_thr <= '0;
      rx_thr <= '0;
      ie_tx  <= 1'b0;
      ie_rx  <= 1'b0;
      dma_tx <= 1'b0;
      dma_rx <= 1'b0;
    end else if (wr) begin
      case (reg_sel_e'(sel))
        SEL_TRIG: begin
          tx_en  <= wdata[TX_EN_BIT];
          rx_en  <= wdata[RX_EN_BIT];
          tx_thr <= wdata[TX_THR_LSB +: THR_W];
          rx_thr <= wdata[RX_THR_LSB +: THR_W];
        end
        SEL_IE: begin
          ie_tx <= wdata[IE_TX_BIT];
          ie_rx <= wdata[IE_RX_BIT];
        end
        SEL_CFG: begin
          dma_tx <= wdata[DMA_TX_BIT];
          dma_rx <= wdata[DMA_RX_BIT];
        end
        default: ;
      endcase
    end
  end

  AST_SEL_NONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd3) |=> ($stable(tx_en) && $stable(rx_en) && $stable(ie_tx)
                             && $stable(ie_rx) && $stable(dma_tx) && $stable(dma_rx))); // R8
endmodule

// File: rtl/lvltrig_rx_lvl.sv
module lvltrig_rx_lvl #(
  parameter int CNT_W = 5,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic             push_ok,
  output logic             trig
);
  logic             armed;
  logic [CNT_W-1:0] thr_ext;

  assign thr_ext = CNT_W'(thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             armed <= 1'b0;
    else if (!en)                           armed <= 1'b0;
    else if (push_ok && count_nxt > thr_ext) armed <= 1'b1;
    else if (count_nxt <= thr_ext)          armed <= 1'b0;
  end

  assign trig = en & armed & (count > thr_ext);

  AST_RX_ARM_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(push_ok)); // R5
  AST_RX_DISARM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !armed); // R7
endmodule

// File: rtl/lvltrig_tx_lvl.sv
module lvltrig_tx_lvl #(
  parameter int CNT_W = 5,
  parameter int THR_W = 4
) (
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  input  logic [CNT_W-1:0] count,
  output logic             trig
);
  assign trig = en & (count <= CNT_W'(thr));
endmodule

// File: rtl/fifo_level_trigger.sv
module fifo_level_trigger
  import lvltrig_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_push,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count,
  output logic              tx_trig,
  output logic              rx_trig,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req
);
  logic [N_DIR-1:0] push_v, pop_v, push_ok_v;
  logic [CNT_W-1:0] cnt_v     [N_DIR];
  logic [CNT_W-1:0] cnt_nxt_v [N_DIR];

  logic             tx_en, rx_en, ie_tx, ie_rx, dma_tx, dma_rx;
  logic [THR_W-1:0] tx_thr, rx_thr;

  assign push_v = {rx_push, tx_push};
  assign pop_v  = {rx_pop,  tx_pop};

  for (genvar d = 0; d < N_DIR; d++) begin : g_occ
    lvltrig_occ #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_v[d]),
      .pop       (pop_v[d]),
      .count     (cnt_v[d]),
      .count_nxt (cnt_nxt_v[d]),
      .push_ok   (push_ok_v[d])
    );
  end

  assign tx_count = cnt_v[DIR_TX];
  assign rx_count = cnt_v[DIR_RX];

  lvltrig_regs #(.THR_W(THR_W), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .tx_en  (tx_en),
    .rx_en  (rx_en),
    .tx_thr (tx_thr),
    .rx_thr (rx_thr),
    .ie_tx  (ie_tx),
    .ie_rx  (ie_rx),
    .dma_tx (dma_tx),
    .dma_rx (dma_rx)
  );

  lvltrig_tx_lvl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_tx_lvl (
    .en    (tx_en),
    .thr   (tx_thr),
    .count (cnt_v[DIR_TX]),
    .trig  (tx_trig)
  );

  lvltrig_rx_lvl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_rx_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .thr       (rx_thr),
    .count     (cnt_v[DIR_RX]),
    .count_nxt (cnt_nxt_v[DIR_RX]),
    .push_ok   (push_ok_v[DIR_RX]),
    .trig      (rx_trig)
  );

  // Routing of each trigger to the interrupt and DMA outputs
  assign irq        = (tx_trig & ie_tx) | (rx_trig & ie_rx);
  assign tx_dma_req = tx_trig & dma_tx;
  assign rx_dma_req = rx_trig & dma_rx;

  AST_TX_EMPTY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_count == '0) |-> tx_trig); // R3
  AST_RX_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig |-> (rx_count != '0)); // R4
  AST_IRQ_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_trig && !rx_trig) |-> !irq); // R8
  AST_TX_DMA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> tx_trig); // R9
  AST_RX_DMA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> rx_trig); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq && !tx_dma_req && !rx_dma_req)); // R10
endmodule

// File: tb/fifo_level_trigger_test.sv
`timescale 1ns/100ps
module fifo_level_trigger_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic        cfg_wr = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [4:0]  tx_count, rx_count;
  logic        tx_trig, rx_trig, irq, tx_dma_req, rx_dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_level_trigger uut (
    .clk(clk), .rst_n(rst_n),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_trig(tx_trig), .rx_trig(rx_trig), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  typedef struct packed {
    logic       tp, tpo, rp, rpo;
    logic [4:0] etc, erc;
    logic       ett, ert;
  } vec_t;

  // tx threshold 2, rx threshold 3, all routing on
  localparam vec_t VEC [12] = '{
    '{1'b1,1'b0,1'b1,1'b0, 5'd1, 5'd1, 1'b1, 1'b0},
    '{1'b1,1'b0,1'b1,1'b0, 5'd2, 5'd2, 1'b1, 1'b0},
    '{1'b1,1'b0,1'b1,1'b0, 5'd3, 5'd3, 1'b0, 1'b0},
    '{1'b1,1'b0,1'b1,1'b0, 5'd4, 5'd4, 1'b0, 1'b1},
    '{1'b1,1'b1,1'b1,1'b1, 5'd4, 5'd4, 1'b0, 1'b1},
    '{1'b0,1'b1,1'b0,1'b1, 5'd3, 5'd3, 1'b0, 1'b0},
    '{1'b0,1'b1,1'b1,1'b0, 5'd2, 5'd4, 1'b1, 1'b1},
    '{1'b0,1'b1,1'b0,1'b1, 5'd1, 5'd3, 1'b1, 1'b0},
    '{1'b0,1'b1,1'b0,1'b1, 5'd0, 5'd2, 1'b1, 1'b0},
    '{1'b0,1'b1,1'b0,1'b1, 5'd0, 5'd1, 1'b1, 1'b0},
    '{1'b0,1'b0,1'b0,1'b1, 5'd0, 5'd0, 1'b1, 1'b0},
    '{1'b0,1'b0,1'b0,1'b1, 5'd0, 5'd0, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic tp, input logic tpo, input logic rp, input logic rpo);
    tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo;
    @(negedge clk);
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    check("R10 irq in reset", irq, 0);
    check("R10 tx_dma in reset", tx_dma_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 tx_count", tx_count, 0);
    check("R10 rx_count", rx_count, 0);
    check("R10 tx_trig", tx_trig, 0);
    check("R10 rx_trig", rx_trig, 0);
    check("R10 irq", irq, 0);

    wr(2'd0, 32'h0003_0203);
    wr(2'd1, 32'h0000_000C);
    wr(2'd2, 32'h0000_3000);
    check("R3 tx_trig empty", tx_trig, 1);
    check("R9 tx_dma empty", tx_dma_req, 1);

    foreach (VEC[i]) begin
      step(VEC[i].tp, VEC[i].tpo, VEC[i].rp, VEC[i].rpo);
      check("R1 tx_count", tx_count, VEC[i].etc);
      check("R1 rx_count", rx_count, VEC[i].erc);
      check("R3 tx_trig", tx_trig, VEC[i].ett);
      check("R4 rx_trig", rx_trig, VEC[i].ert);
      check("R8 irq", irq, VEC[i].ett | VEC[i].ert);
      check("R9 tx_dma", tx_dma_req, VEC[i].ett);
      check("R9 rx_dma", rx_dma_req, VEC[i].ert);
    end

    // R7: tx enable cleared while tx count is 0
    wr(2'd0, 32'h0003_0202);
    check("R7 tx_trig off", tx_trig, 0);
    check("R7 tx_dma off", tx_dma_req, 0);
    check("R7 irq off", irq, 0);

    // Both thresholds 15, fill to full
    wr(2'd0, 32'h000F_0F03);
    for (int k = 0; k < 15; k++) step(1, 0, 1, 0);
    check("R4 rx_trig at 15 of thr 15", rx_trig, 0);
    step(1, 0, 1, 0);
    check("R4 rx_trig full", rx_trig, 1);
    check("R1 rx_count full", rx_count, 16);
    check("R3 tx_trig full", tx_trig, 0);
    step(1, 0, 1, 0);
    check("R2 tx_count push at full", tx_count, 16);
    check("R2 rx_count push at full", rx_count, 16);
    check("R4 rx_trig held", rx_trig, 1);
    step(0, 0, 1, 1);
    check("R1 rx_count push+pop at full", rx_count, 16);
    step(1, 1, 0, 0);
    check("R1 tx_count push+pop at full", tx_count, 16);
    step(0, 1, 0, 0);
    check("R3 tx_trig no longer full", tx_trig, 1);
    check("R3 tx_count", tx_count, 15);

    // R6: pop back to threshold
    step(0, 0, 0, 1);
    check("R6 rx_trig cleared", rx_trig, 0);

    // R5: lower threshold with no arrival
    wr(2'd0, 32'h0003_0F03);
    step(0, 0, 0, 0);
    check("R5 rx_trig no arrival", rx_trig, 0);
    check("R5 rx_count", rx_count, 15);
    step(0, 0, 1, 0);
    check("R5 rx_trig after arrival", rx_trig, 1);

    // R8: interrupt routing
    wr(2'd0, 32'h0003_0002);
    wr(2'd1, 32'h0000_0004);
    check("R8 rx_trig raw", rx_trig, 1);
    check("R8 irq tx-only enable", irq, 0);
    wr(2'd1, 32'h0000_0008);
    check("R8 irq rx enable", irq, 1);
    wr(2'd3, 32'hFFFF_FFFF);
    check("R8 sel3 tx_trig", tx_trig, 0);
    check("R8 sel3 irq", irq, 1);
    check("R8 sel3 tx_dma", tx_dma_req, 0);

    // R9: DMA routing independent of irq
    wr(2'd2, 32'h0000_1000);
    check("R9 rx_dma off", rx_dma_req, 0);
    check("R9 irq kept", irq, 1);
    wr(2'd2, 32'h0000_2000);
    check("R9 rx_dma on", rx_dma_req, 1);

    // R10: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 tx_count after reset", tx_count, 0);
    check("R10 rx_count after reset", rx_count, 0);
    check("R10 tx_trig after reset", tx_trig, 0);
    check("R10 rx_trig after reset", rx_trig, 0);
    check("R10 irq after reset", irq, 0);
    check("R10 rx_dma after reset", rx_dma_req, 0);
    step(1, 0, 1, 0);
    check("R10 settings cleared", tx_trig | rx_trig, 0);

    finish_run();
  end
endmodule